// File: doc/BRIEF.md
# Late-Write Synchronous Burst SRAM

This block is a single-port synchronous SRAM whose data bus never needs a dead cycle between a read and a write. Write data follows its command by the same number of cycles as read data does, so a controller can issue read, write, read on consecutive edges and the bus carries one access per cycle. A static mode input picks one of two latencies. In pipelined mode, read data is presented one cycle after the capturing edge and write data is sampled two edges after the command. In flow-through mode, read data appears in the same cycle and write data is sampled on the next edge.

Each access may start a burst of four words. The low two address bits then come from an internal counter that steps through either a linear or an exclusive-or order, while the upper bits stay fixed. Writes are masked per 9-bit byte. A read that is captured while an older write to the same word still waits for its data gets the pending bytes merged in. The bidirectional data bus is split into an input, an output and a drive enable. The array is a small register file, and the mode input must be tied (low for pipelined) and held steady while traffic is in flight.

Top module: `lwb_sram`

## Requirements
- R1: A command is accepted on an edge with cke_n low when ce1_n is low, ce2 is high, ce3_n is low and sleep is low, and adv is low; it is a read when we_n is high. With flow_mode low (pipelined), the read word is driven (dq_oe high) during the cycle after the following edge. If any one chip enable is inactive, no command is taken.
- R2: With flow_mode high, the read word is driven in the cycle right after its capturing edge.
- R3: In pipelined mode, the write data for a command captured on edge k is sampled from dq_in on edge k+2.
- R4: In flow-through mode, the write data for a command captured on edge k is sampled on edge k+1.
- R5: bw_n bit i (active low) enables data bits [9i+8:9i]. A write beat with all bw_n bits high changes no memory word, but the burst counter still steps past it.
- R6: An edge with cke_n high changes no internal state, and the outputs keep their values.
- R7: With adv high during an active burst, the next beat keeps the upper address bits and the read/write type of the start command. With ilv_order low at the start, the low two bits are (start + n) mod 4. After four beats the sequence returns to the start word. The chip enables are not looked at during continuation.
- R8: With ilv_order high at the burst start, the low two bits of beat n are start XOR n.
- R9: dq_oe is low whenever oe_n or sleep is high. While sleep is high, no command is accepted and the burst ends.
- R10: In pipelined mode, a read captured one edge after a write to the same word returns the bytes of that write (enabled bytes, taken from dq_in at the write's data edge) merged with the stored bytes.
- R11: A deselect (adv low with any chip enable inactive) ends the burst. dq_oe returns low once the reads already in flight have been presented.
- R12: While rst_n is low, dq_oe is low and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flow_mode | input | 1 | 0 pipelined, 1 flow-through (static) |
| cke_n | input | 1 | Clock enable, active low; high stalls the edge |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| bw_n | input | NB | Per-byte write enables, active low |
| adv | input | 1 | 0 load a new address, 1 continue the burst |
| ilv_order | input | 1 | Burst order at start: 0 linear, 1 interleaved |
| oe_n | input | 1 | Output enable, active low |
| sleep | input | 1 | Power-down: blocks commands and the bus drive |
| addr | input | AW | Word address |
| dq_in | input | NB*9 | Write data from the shared bus |
| dq_out | output | NB*9 | Read data onto the shared bus |
| dq_oe | output | 1 | Drive enable for dq_out |

## Verification
The hardest case to reach is a read captured one edge after a partial write to the same word in pipelined mode. The merged word exists only during the single edge on which the write's data arrives. The stimulus table writes a full word, then issues a one-byte write to it followed at once by a read. This places the byte data on dq_in exactly on the edge where the read result is registered, and a stalled edge follows so that the held result is also checked. Burst ordering is reached by writing a linear burst that wraps through the low address bits and reading it back in interleaved order past its fourth beat.

// File: rtl/lwb_pkg.sv
package lwb_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // low two address bits of burst beat n
  function automatic logic [1:0] beat_lsb(input logic [1:0] start,
                                          input logic [1:0] n,
                                          input logic       ilv);
    return ilv ? (start ^ n) : (start + n);
  endfunction

endpackage

// File: rtl/lwb_rst_sync.sv
module lwb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/lwb_burst.sv
module lwb_burst #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          load,
  input  logic          cont,
  input  logic          stop,
  input  logic [AW-1:0] addr_in,
  input  logic          wr_in,
  input  logic          ilv_in,
  output logic [AW-1:0] acc_addr,
  output logic          acc_wr,
  output logic          active,
  output logic [1:0]    cnt
);
  import lwb_pkg::*;

  logic          act_q, act_d;
  logic [AW-1:0] base_q, base_d;
  logic          wr_q, wr_d;
  logic          ilv_q, ilv_d;
  logic [1:0]    cnt_q, cnt_d;

  always_comb begin
    act_d  = act_q;
    base_d = base_q;
    wr_d   = wr_q;
    ilv_d  = ilv_q;
    cnt_d  = cnt_q;
    if (load) begin
      act_d  = 1'b1;
      base_d = addr_in;
      wr_d   = wr_in;
      ilv_d  = ilv_in;
      cnt_d  = 2'd1;
    end else if (cont) begin
      cnt_d  = cnt_q + 2'd1;
    end else if (stop) begin
      act_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      base_q <= '0;
      wr_q   <= 1'b0;
      ilv_q  <= 1'b0;
      cnt_q  <= 2'd0;
    end else if (en) begin
      act_q  <= act_d;
      base_q <= base_d;
      wr_q   <= wr_d;
      ilv_q  <= ilv_d;
      cnt_q  <= cnt_d;
    end
  end

  assign acc_addr = load ? addr_in
                         : {base_q[AW-1:2], beat_lsb(base_q[1:0], cnt_q, ilv_q)};
  assign acc_wr   = load ? wr_in : wr_q;
  assign active   = act_q;
  assign cnt      = cnt_q;
endmodule

// File: rtl/lwb_array.sv
module lwb_array #(
  parameter int AW = 6,
  parameter int NB = 2,
  parameter int BW = 9
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [NB-1:0]    wr_be,
  input  logic [NB*BW-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [NB*BW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;
  localparam int DW    = NB * BW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < NB; b++) begin
        if (wr_be[b]) mem[wr_addr][b*BW +: BW] <= wr_data[b*BW +: BW];
      end
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/lwb_sram.sv
module lwb_sram #(
  parameter int AW = 6,
  parameter int NB = 2,
  parameter int BW = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flow_mode,
  input  logic             cke_n,
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             we_n,
  input  logic [NB-1:0]    bw_n,
  input  logic             adv,
  input  logic             ilv_order,
  input  logic             oe_n,
  input  logic             sleep,
  input  logic [AW-1:0]    addr,
  input  logic [NB*BW-1:0] dq_in,
  output logic [NB*BW-1:0] dq_out,
  output logic             dq_oe
);
  import lwb_pkg::*;

  localparam int DW = NB * BW;

  logic rst_sync_n;
  lwb_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  // command decode
  logic en, chip_sel, load, cont, stop;
  assign en       = ~cke_n;
  assign chip_sel = ~ce1_n & ce2 & ~ce3_n & ~sleep;
  assign load     = ~adv & chip_sel;
  assign cont     = adv & burst_act & ~sleep;
  assign stop     = ~adv | sleep;

  logic [AW-1:0] acc_addr;
  logic          acc_wr, burst_act;
  logic [1:0]    burst_cnt;

  lwb_burst #(.AW(AW)) u_burst (
    .clk(clk), .rst_n(rst_sync_n), .en(en),
    .load(load), .cont(cont), .stop(stop),
    .addr_in(addr), .wr_in(~we_n), .ilv_in(ilv_order),
    .acc_addr(acc_addr), .acc_wr(acc_wr),
    .active(burst_act), .cnt(burst_cnt)
  );

  // two command stages: s1 = captured last edge, s2 = one edge older
  op_e           s1_op, s1_op_d, s2_op;
  logic [AW-1:0] s1_addr, s2_addr;
  logic [NB-1:0] s1_be, s2_be;

  always_comb begin
    if (load | cont) s1_op_d = acc_wr ? OP_WR : OP_RD;
    else             s1_op_d = OP_NONE;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s1_op <= OP_NONE;
      s2_op <= OP_NONE;
    end else if (en) begin
      s1_op <= s1_op_d;
      s2_op <= s1_op;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      s1_addr <= acc_addr;
      s1_be   <= ~bw_n;
      s2_addr <= s1_addr;
      s2_be   <= s1_be;
    end
  end

  // late write commit: flow-through from s1, pipelined from s2
  logic          cm_we;
  logic [AW-1:0] cm_addr;
  logic [NB-1:0] cm_be;
  logic [DW-1:0] rd_data;

  always_comb begin
    if (flow_mode) begin
      cm_we   = en & (s1_op == OP_WR);
      cm_addr = s1_addr;
      cm_be   = s1_be;
    end else begin
      cm_we   = en & (s2_op == OP_WR);
      cm_addr = s2_addr;
      cm_be   = s2_be;
    end
  end

  lwb_array #(.AW(AW), .NB(NB), .BW(BW)) u_array (
    .clk(clk), .wr_en(cm_we), .wr_addr(cm_addr), .wr_be(cm_be),
    .wr_data(dq_in), .rd_addr(s1_addr), .rd_data(rd_data)
  );

  // coherency: merge bytes of the write committing on this same edge
  logic          fwd_hit;
  logic [DW-1:0] merged;
  assign fwd_hit = (s2_op == OP_WR) && (s2_addr == s1_addr);

  for (genvar b = 0; b < NB; b++) begin : g_fwd
    assign merged[b*BW +: BW] = (fwd_hit && s2_be[b]) ? dq_in[b*BW +: BW]
                                                      : rd_data[b*BW +: BW];
  end

  // pipelined output register
  logic [DW-1:0] rd_q;
  logic          rd_v;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rd_v <= 1'b0;
    else if (en)     rd_v <= (s1_op == OP_RD);
  end

  always_ff @(posedge clk) begin
    if (en) rd_q <= merged;
  end

  logic pres_v;
  assign pres_v = flow_mode ? (s1_op == OP_RD) : rd_v;
  assign dq_out = flow_mode ? rd_data : rd_q;
  assign dq_oe  = pres_v & ~oe_n & ~sleep & rst_n;
endmodule

// File: rtl/lwb_sram_chk.sv
module lwb_sram_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cke_n,
  input logic       adv,
  input logic       ce1_n,
  input logic       ce2,
  input logic       ce3_n,
  input logic       sleep,
  input logic       oe_n,
  input logic       flow_mode,
  input logic       dq_oe,
  input logic [1:0] s1_op,
  input logic [1:0] s2_op,
  input logic       rd_v,
  input logic       burst_act,
  input logic [1:0] burst_cnt
);
  // R6: a stalled edge leaves the command stages and counter untouched
  a_r6_stall_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> ($stable(s1_op) && $stable(s2_op) && $stable(burst_cnt)));

  // R7: each continued beat steps the counter by one, modulo four
  a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && adv && burst_act && !sleep) |=> (burst_cnt == $past(burst_cnt) + 2'd1));

  // R11: deselect ends the burst
  a_r11_burst_end: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !adv && !(!ce1_n && ce2 && !ce3_n)) |=> !burst_act);

  // R1: a captured read is presented after the next edge in pipelined mode
  a_r1_pipe_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !flow_mode && s1_op == 2'd1) |=> rd_v);

  // R9: the bus is never driven while output enable or sleep blocks it
  a_r9_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!oe_n && !sleep));
endmodule

bind lwb_sram lwb_sram_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cke_n(cke_n), .adv(adv),
  .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .sleep(sleep), .oe_n(oe_n),
  .flow_mode(flow_mode), .dq_oe(dq_oe), .s1_op(s1_op), .s2_op(s2_op),
  .rd_v(rd_v), .burst_act(burst_act), .burst_cnt(burst_cnt)
);

// File: tb/lwb_sram_test.sv
module lwb_sram_test;
  localparam logic [2:0] SEL = 3'b010;  // {ce1_n, ce2, ce3_n}
  localparam logic [2:0] DES = 3'b101;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, flow_mode, cke_n, ce1_n, ce2, ce3_n, we_n, adv;
  logic        ilv_order, oe_n, sleep;
  logic [1:0]  bw_n;
  logic [5:0]  addr;
  logic [17:0] dq_in, dq_out;
  logic        dq_oe;

  lwb_sram uut (
    .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode), .cke_n(cke_n),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .we_n(we_n), .bw_n(bw_n),
    .adv(adv), .ilv_order(ilv_order), .oe_n(oe_n), .sleep(sleep),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  int checks = 0;
  int fails  = 0;

  function automatic logic [17:0] pat(input logic [5:0] a);
    return {a, ~a, a};
  endfunction

  task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one cycle's inputs at a negedge, return at the next negedge
  task automatic step(input logic ck, input logic [2:0] ce, input logic wn,
                      input logic av, input logic [1:0] bn, input logic [5:0] a,
                      input logic [17:0] d);
    cke_n = ck; {ce1_n, ce2, ce3_n} = ce; we_n = wn; adv = av;
    bw_n = bn; addr = a; dq_in = d;
    @(negedge clk);
  endtask

  typedef struct packed {
    logic        ck; logic [2:0] ce; logic wn; logic av; logic [1:0] bn;
    logic [5:0]  a;  logic [17:0] d; logic eoe; logic [17:0] eq;
  } vec_t;

  // pipelined: back-to-back W/W/R/W/R/R, partial write hazard, stall,
  // deselect drain, no-op write
  localparam vec_t TBL [13] = '{
    '{1'b0, SEL, 1'b0, 1'b0, 2'b00, 6'd5, 18'h00000, 1'b0, 18'h00000},
    '{1'b0, SEL, 1'b0, 1'b0, 2'b00, 6'd7, 18'h00000, 1'b0, 18'h00000},
    '{1'b0, SEL, 1'b1, 1'b0, 2'b00, 6'd5, 18'h0A5A5, 1'b0, 18'h00000},
    '{1'b0, SEL, 1'b0, 1'b0, 2'b10, 6'd7, 18'h1C3C3, 1'b1, 18'h0A5A5},
    '{1'b0, SEL, 1'b1, 1'b0, 2'b11, 6'd7, 18'h00000, 1'b0, 18'h00000},
    '{1'b0, SEL, 1'b1, 1'b0, 2'b11, 6'd7, 18'h3FE12, 1'b1, 18'h1C212},
    '{1'b1, SEL, 1'b1, 1'b0, 2'b11, 6'd5, 18'h00000, 1'b1, 18'h1C212},
    '{1'b0, DES, 1'b1, 1'b0, 2'b11, 6'd0, 18'h00000, 1'b1, 18'h1C212},
    '{1'b0, SEL, 1'b0, 1'b0, 2'b11, 6'd5, 18'h00000, 1'b0, 18'h00000},
    '{1'b0, DES, 1'b1, 1'b0, 2'b11, 6'd0, 18'h00000, 1'b0, 18'h00000},
    '{1'b0, SEL, 1'b1, 1'b0, 2'b11, 6'd5, 18'h3FFFF, 1'b0, 18'h00000},
    '{1'b0, DES, 1'b1, 1'b0, 2'b11, 6'd0, 18'h00000, 1'b1, 18'h0A5A5},
    '{1'b0, DES, 1'b1, 1'b0, 2'b11, 6'd0, 18'h00000, 1'b0, 18'h00000}
  };

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; flow_mode = 1'b0; ilv_order = 1'b0; oe_n = 1'b0; sleep = 1'b0;
    cke_n = 1'b0; {ce1_n, ce2, ce3_n} = DES; we_n = 1'b1; adv = 1'b0;
    bw_n = 2'b11; addr = '0; dq_in = '0;
    repeat (3) @(negedge clk);
    check("R12 oe in reset", {17'd0, dq_oe}, 18'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R12 oe after reset", {17'd0, dq_oe}, 18'd0);

    // table walk: R1 R3 R5 R6 R10 R11
    for (int i = 0; i < 13; i++) begin
      step(TBL[i].ck, TBL[i].ce, TBL[i].wn, TBL[i].av, TBL[i].bn, TBL[i].a, TBL[i].d);
      check($sformatf("R1 R3 R10 table oe step %0d", i), {17'd0, dq_oe}, {17'd0, TBL[i].eoe});
      if (TBL[i].eoe)
        check($sformatf("R5 R6 R10 table data step %0d", i), dq_out, TBL[i].eq);
    end

    // R1: one chip enable inactive means no command
    step(1'b0, 3'b000, 1'b1, 1'b0, 2'b11, 6'd5, 18'd0);
    step(1'b0, DES, 1'b1, 1'b0, 2'b11, 6'd0, 18'd0);
    check("R1 ce2 low blocks read", {17'd0, dq_oe}, 18'd0);

    // R7: linear write burst from 10 -> 10,11,8,9 (continuation with ce inactive)
    ilv_order = 1'b0;
    step(1'b0, SEL, 1'b0, 1'b0, 2'b00, 6'd10, 18'd0);
    step(1'b0, DES, 1'b1, 1'b1, 2'b00, 6'd0, 18'd0);
    step(1'b0, DES, 1'b1, 1'b1, 2'b00, 6'd0, pat(6'd10));
    step(1'b0, DES, 1'b1, 1'b1, 2'b00, 6'd0, pat(6'd11));
    step(1'b0, DES, 1'b1, 1'b0, 2'b11, 6'd0, pat(6'd8));
    step(1'b0, DES, 1'b1, 1'b0, 2'b11, 6'd0, pat(6'd9));
    // R8: interleaved read from 9 -> 9,8,11,10 then wrap to 9
    ilv_order = 1'b1;
    step(1'b0, SEL, 1'b1, 1'b0, 2'b11, 6'd9, 18'd0);
    check("R1 pipelined read not yet driven", {17'd0, dq_oe}, 18'd0);
    ilv_order = 1'b0;
    step(1'b0, DES, 1'b0, 1'b1, 2'b11, 6'd0, 18'd0);
    check("R8 beat0", dq_out, pat(6'd9));
    check("R1 oe beat0", {17'd0, dq_oe}, 18'd1);
    step(1'b0, DES, 1'b0, 1'b1, 2'b11, 6'd0, 18'd0);
    check("R8 beat1", dq_out, pat(6'd8));
    step(1'b0, DES, 1'b0, 1'b1, 2'b11, 6'd0, 18'd0);
    check("R8 beat2 / R7 linear write", dq_out, pat(6'd11));
    step(1'b0, DES, 1'b0, 1'b1, 2'b11, 6'd0, 18'd0);
    check("R8 beat3", dq_out, pat(6'd10));
    step(1'b0, DES, 1'b1, 1'b0, 2'b11, 6'd0, 18'd0);
    check("R7 wrap to start", dq_out, pat(6'd9));
    step(1'b0, DES, 1'b1, 1'b0, 2'b11, 6'd0, 18'd0);
    check("R11 drained", {17'd0, dq_oe}, 18'd0);

    // flow-through mode
    flow_mode = 1'b1;
    step(1'b0, SEL, 1'b0, 1'b0, 2'b00, 6'd20, 18'd0);
    check("R4 write no drive", {17'd0, dq_oe}, 18'd0);
    step(1'b0, SEL, 1'b0, 1'b0, 2'b00, 6'd23, pat(6'd20));
    step(1'b0, SEL, 1'b1, 1'b0, 2'b11, 6'd20, pat(6'd23));
    check("R2 same-cycle oe", {17'd0, dq_oe}, 18'd1);
    check("R2 R4 same-cycle data", dq_out, pat(6'd20));
    step(1'b0, SEL, 1'b0, 1'b0, 2'b00, 6'd22, 18'd0);
    step(1'b0, DES, 1'b1, 1'b1, 2'b11, 6'd0, pat(6'd22));
    step(1'b0, DES, 1'b1, 1'b1, 2'b00, 6'd0, 18'h3FFFF);
    step(1'b0, SEL, 1'b1, 1'b0, 2'b11, 6'd23, 18'h00055);
    check("R5 no-op beat kept word", dq_out, pat(6'd23));
    step(1'b0, SEL, 1'b1, 1'b0, 2'b11, 6'd20, 18'd0);
    check("R5 counter stepped past no-op", dq_out, 18'h00055);
    step(1'b0, SEL, 1'b1, 1'b0, 2'b11, 6'd22, 18'd0);
    check("R7 burst start word", dq_out, pat(6'd22));

    // R9: output enable and sleep
    oe_n = 1'b1;
    step(1'b0, SEL, 1'b1, 1'b0, 2'b11, 6'd22, 18'd0);
    check("R9 oe_n high", {17'd0, dq_oe}, 18'd0);
    oe_n = 1'b0; #1;
    check("R9 oe_n low again", {17'd0, dq_oe}, 18'd1);
    @(negedge clk);
    sleep = 1'b1;
    step(1'b0, SEL, 1'b1, 1'b0, 2'b11, 6'd20, 18'd0);
    check("R9 sleep tri-states", {17'd0, dq_oe}, 18'd0);
    sleep = 1'b0; #1;
    check("R9 command in sleep ignored", {17'd0, dq_oe}, 18'd0);
    @(negedge clk);

    // R6: flow-through stall
    step(1'b0, SEL, 1'b1, 1'b0, 2'b11, 6'd20, 18'd0);
    step(1'b1, SEL, 1'b1, 1'b0, 2'b11, 6'd22, 18'd0);
    check("R6 stall holds oe", {17'd0, dq_oe}, 18'd1);
    check("R6 stall holds data", dq_out, 18'h00055);
    step(1'b0, DES, 1'b1, 1'b0, 2'b11, 6'd0, 18'd0);
    check("R11 deselect flow", {17'd0, dq_oe}, 18'd0);

    // R12: reset while presenting
    flow_mode = 1'b0;
    step(1'b0, SEL, 1'b1, 1'b0, 2'b11, 6'd20, 18'd0);
    step(1'b0, DES, 1'b1, 1'b0, 2'b11, 6'd0, 18'd0);
    check("R10 pipelined read before reset", dq_out, 18'h00055);
    rst_n = 1'b0; #1;
    check("R12 reset mid-stream", {17'd0, dq_oe}, 18'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R12 idle after reset", {17'd0, dq_oe}, 18'd0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule